// File: doc/BRIEF.md
# Digital Potentiometer Register Controller

This block is the register and control core of a single-channel digitally controlled potentiometer. It keeps the live wiper position, a non-volatile-backed start-up position and a small control register. It selects one of the taps of an external resistor ladder through a tap-select output, and it drives a shutdown output that puts the ladder into its disconnected state. A serial bus front end sits in front of it and talks to it through a plain parallel register port (address, write data, write enable, read enable, read data).

After reset the wiper sits at midscale. When the non-volatile store reports that it is readable, the stored start-up position is copied into the wiper once. Bus writes to the wiper that arrive before that copy are held and applied in place of it, so they are never lost. A mode bit decides whether a wiper write also updates the stored start-up value. Updating that store takes a fixed number of clock cycles, and a busy flag covers those cycles. Shutdown comes either from an active-low pin or from a run bit in the control register. While it is active, every register stays readable and writable, and the wiper setting is kept so that it comes back when shutdown ends.

Top module: `dpot_regctl`

## Requirements
- R1: While not in shutdown, `tap_sel` equals the 7-bit wiper register. A write to address 0 loads `reg_wdata[6:0]` into the wiper, and `tap_sel` shows the new value after the write's clock edge. Bit 7 of the write data is dropped.
- R2: After reset and until the recall has happened, the wiper register holds 40h (midscale), and address 0 reads back 40h in volatile mode.
- R3: At the first clock edge after reset where `nv_ready` is high, the wiper register is loaded from the initial value register. That register holds `IVR_INIT` (default 15h) after reset.
- R4: The recall happens only once per reset. Later changes on `nv_ready` do not change the wiper.
- R5: Writes to address 0 made before the recall are held. At the recall edge the wiper takes the most recent held value instead of the initial value register.
- R6: Address map: 0 is the wiper register and initial value register, 1 and 3 are reserved, and 2 is the control register. Reserved addresses read 00h, and writes to them change nothing.
- R7: Control register (address 2): bit 7 is the run bit (reset 1), bit 6 is the non-volatile mode bit (reset 0), bit 5 is the read-only busy flag, and all other bits read 0. Address 0 reads `{0, wiper}` in volatile mode and `{0, initial value}` in non-volatile mode. Bit 7 always reads 0.
- R8: In non-volatile mode, a write to address 0 loads both the wiper and the initial value register, then holds busy high for `NV_BUSY_CYCLES` cycles. While busy is high, the initial value register ignores writes, but the wiper still takes them. A write in volatile mode leaves the initial value register unchanged.
- R9: Shutdown is active when `shdn_n_pin` is low or the run bit is 0. In shutdown, `shutdown_o` is 1 and `tap_sel` is 0. The wiper register is kept, and `tap_sel` returns to it when shutdown ends.
- R10: While shutdown is active, all registers can still be read and written.
- R11: `reg_rdata` is registered. It shows the addressed value one cycle after a clock edge with `reg_re` high, and it holds its value when `reg_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-up) |
| nv_ready | input | 1 | Non-volatile store readable; triggers the one-time recall |
| shdn_n_pin | input | 1 | Active-low shutdown pin |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write enable |
| reg_re | input | 1 | Read enable |
| reg_rdata | output | 8 | Registered read data |
| tap_sel | output | 7 | Selected ladder tap (0 in shutdown) |
| shutdown_o | output | 1 | Ladder disconnected, wiper grounded |

## Verification
The hardest situation to reach is a wiper write that lands in the window between reset and recall, because it interacts with the copy from the non-volatile store. The stimulus holds `nv_ready` low through a second reset, writes the wiper, checks that the tap has not moved, and then raises `nv_ready` to show that the held value wins over the stored one. The busy window is reached by writing in non-volatile mode and then issuing a second store write and a control read inside the window, before waiting for it to close.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
   localparam int DATA_W = 8;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      ADR_WIPER = 2'd0,
      ADR_RSVD  = 2'd1,
      ADR_CTRL  = 2'd2,
      ADR_SPARE = 2'd3
   } addr_e;

   localparam int CTL_RUN  = 7;
   localparam int CTL_NVM  = 6;
   localparam int CTL_BUSY = 5;

   typedef enum logic {
      RC_WAIT = 1'b0,
      RC_DONE = 1'b1
   } recall_e;
endpackage

// File: rtl/dpot_nvstore.sv
module dpot_nvstore #(
   parameter int W           = 7,
   parameter int BUSY_CYCLES = 16,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_req,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] ivr_q,
   output logic         busy
);
   localparam int CW = $clog2(BUSY_CYCLES + 1);

   logic [CW-1:0] cnt_q;

   assign busy = (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ivr_q <= INIT;
         cnt_q <= '0;
      end else if (wr_req && !busy) begin
         ivr_q <= wr_data;
         cnt_q <= CW'(BUSY_CYCLES);
      end else if (busy) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/dpot_wiper.sv
module dpot_wiper
   import dpot_pkg::*;
#(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         nv_ready,
   input  logic         wr_req,
   input  logic [W-1:0] wr_data,
   input  logic [W-1:0] ivr,
   output logic [W-1:0] wiper_q,
   output logic         recall_done,
   output logic         held_valid
);
   localparam logic [W-1:0] MID = W'(1) << (W - 1);

   recall_e        state_q;
   logic [W-1:0]   held_q;

   assign recall_done = (state_q == RC_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wiper_q    <= MID;
         state_q    <= RC_WAIT;
         held_valid <= 1'b0;
         held_q     <= '0;
      end else begin
         case (state_q)
            RC_WAIT: begin
               if (nv_ready) begin
                  if (wr_req)          wiper_q <= wr_data;
                  else if (held_valid) wiper_q <= held_q;
                  else                 wiper_q <= ivr;
                  state_q    <= RC_DONE;
                  held_valid <= 1'b0;
               end else if (wr_req) begin
                  held_valid <= 1'b1;
                  held_q     <= wr_data;
               end
            end
            default: begin
               if (wr_req) wiper_q <= wr_data;
            end
         endcase
      end
   end
endmodule

// File: rtl/dpot_shdn.sv
module dpot_shdn #(
   parameter int W = 7
) (
   input  logic         pin_n,
   input  logic         run_bit,
   input  logic [W-1:0] wiper,
   output logic [W-1:0] tap_sel,
   output logic         shutdown
);
   always_comb begin
      shutdown = ~(pin_n & run_bit);
      tap_sel  = shutdown ? '0 : wiper;
   end
endmodule

// File: rtl/dpot_regctl.sv
module dpot_regctl
   import dpot_pkg::*;
#(
   parameter int           WIPER_W        = 7,
   parameter int           NV_BUSY_CYCLES = 16,
   parameter logic [6:0]   IVR_INIT       = 7'h15,
   parameter bit           RDATA_REG      = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 nv_ready,
   input  logic                 shdn_n_pin,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   input  logic                 reg_we,
   input  logic                 reg_re,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic [WIPER_W-1:0]   tap_sel,
   output logic                 shutdown_o
);
   localparam int PAD_W = DATA_W - WIPER_W;

   if (WIPER_W < 2 || WIPER_W > DATA_W - 1) begin : g_bad_width
      $error("dpot_regctl: WIPER_W must be between 2 and DATA_W-1");
   end
   if (NV_BUSY_CYCLES < 1) begin : g_bad_busy
      $error("dpot_regctl: NV_BUSY_CYCLES must be at least 1");
   end

   logic                 acr_run, acr_nvm;
   logic                 wr_wiper, wr_ivr, wr_ctrl;
   logic [WIPER_W-1:0]   wiper_q, ivr_q;
   logic                 nv_busy, recall_done, held_valid;
   logic [DATA_W-1:0]    rd_sel;

   assign wr_wiper = reg_we && (reg_addr == ADR_WIPER);
   assign wr_ivr   = wr_wiper && acr_nvm;
   assign wr_ctrl  = reg_we && (reg_addr == ADR_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acr_run <= 1'b1;
         acr_nvm <= 1'b0;
      end else if (wr_ctrl) begin
         acr_run <= reg_wdata[CTL_RUN];
         acr_nvm <= reg_wdata[CTL_NVM];
      end
   end

   dpot_nvstore #(
      .W           (WIPER_W),
      .BUSY_CYCLES (NV_BUSY_CYCLES),
      .INIT        (IVR_INIT[WIPER_W-1:0])
   ) u_nv (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (wr_ivr),
      .wr_data (reg_wdata[WIPER_W-1:0]),
      .ivr_q   (ivr_q),
      .busy    (nv_busy)
   );

   dpot_wiper #(.W(WIPER_W)) u_wiper (
      .clk         (clk),
      .rst_n       (rst_n),
      .nv_ready    (nv_ready),
      .wr_req      (wr_wiper),
      .wr_data     (reg_wdata[WIPER_W-1:0]),
      .ivr         (ivr_q),
      .wiper_q     (wiper_q),
      .recall_done (recall_done),
      .held_valid  (held_valid)
   );

   dpot_shdn #(.W(WIPER_W)) u_shdn (
      .pin_n    (shdn_n_pin),
      .run_bit  (acr_run),
      .wiper    (wiper_q),
      .tap_sel  (tap_sel),
      .shutdown (shutdown_o)
   );

   always_comb begin
      rd_sel = '0;
      case (reg_addr)
         ADR_WIPER: rd_sel = acr_nvm ? {{PAD_W{1'b0}}, ivr_q}
                                     : {{PAD_W{1'b0}}, wiper_q};
         ADR_CTRL: begin
            rd_sel[CTL_RUN]  = acr_run;
            rd_sel[CTL_NVM]  = acr_nvm;
            rd_sel[CTL_BUSY] = nv_busy;
         end
         default: rd_sel = '0;
      endcase
   end

   if (RDATA_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n)      reg_rdata <= '0;
         else if (reg_re) reg_rdata <= rd_sel;
      end
   end else begin : g_rd_comb
      assign reg_rdata = reg_re ? rd_sel : '0;
   end
endmodule

// File: rtl/dpot_regctl_chk.sv
module dpot_regctl_chk #(
   parameter int WIPER_W   = 7,
   parameter bit RDATA_REG = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               nv_ready,
   input logic [1:0]         reg_addr,
   input logic               reg_we,
   input logic               reg_re,
   input logic [7:0]         reg_rdata,
   input logic [WIPER_W-1:0] tap_sel,
   input logic               shutdown_o,
   input logic [WIPER_W-1:0] wiper_q,
   input logic [WIPER_W-1:0] ivr_q,
   input logic               nv_busy,
   input logic               recall_done,
   input logic               held_valid,
   input logic               acr_nvm
);
   localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1);

   AST_MID_BEFORE_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
      !recall_done |-> wiper_q == MID); // R2

   AST_RECALL_FROM_IVR: assert property (@(posedge clk) disable iff (!rst_n)
      (!recall_done && nv_ready && !held_valid && !reg_we) |=> wiper_q == $past(ivr_q)); // R3

   AST_RECALL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      recall_done |=> recall_done); // R4

   AST_TAP_FOLLOWS_WIPER: assert property (@(posedge clk) disable iff (!rst_n)
      !shutdown_o |-> tap_sel == wiper_q); // R1

   AST_SHDN_TAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_o |-> tap_sel == '0); // R9

   AST_IVR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      nv_busy |=> ivr_q == $past(ivr_q)); // R8

   AST_BUSY_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd0 && acr_nvm && !nv_busy) |=> nv_busy); // R8

   if (RDATA_REG) begin : g_rd_props
      AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_re && reg_addr[0]) |=> reg_rdata == 8'h00); // R6

      AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !reg_re |=> $stable(reg_rdata)); // R11
   end
endmodule

bind dpot_regctl dpot_regctl_chk #(.WIPER_W(WIPER_W), .RDATA_REG(RDATA_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .nv_ready    (nv_ready),
   .reg_addr    (reg_addr),
   .reg_we      (reg_we),
   .reg_re      (reg_re),
   .reg_rdata   (reg_rdata),
   .tap_sel     (tap_sel),
   .shutdown_o  (shutdown_o),
   .wiper_q     (wiper_q),
   .ivr_q       (ivr_q),
   .nv_busy     (nv_busy),
   .recall_done (recall_done),
   .held_valid  (held_valid),
   .acr_nvm     (acr_nvm)
);

// File: tb/dpot_regctl_test.sv
`timescale 1ns/1ps
module dpot_regctl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       nv_ready = 1'b0;
   logic       shdn_n_pin = 1'b1;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       reg_we = 1'b0;
   logic       reg_re = 1'b0;
   logic [7:0] reg_rdata;
   logic [6:0] tap_sel;
   logic       shutdown_o;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;
   logic mon_arm = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   dpot_regctl uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .nv_ready   (nv_ready),
      .shdn_n_pin (shdn_n_pin),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_we     (reg_we),
      .reg_re     (reg_re),
      .reg_rdata  (reg_rdata),
      .tap_sel    (tap_sel),
      .shutdown_o (shutdown_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      nv_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   // driver: pushes the expected read value into the scoreboard
   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a; reg_re = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      reg_re = 1'b0;
   endtask

   // monitor: compares read data one edge after each read
   always @(posedge clk) mon_arm <= reg_re && rst_n;
   always @(negedge clk) begin
      if (mon_arm) begin
         if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
         else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check("watchdog expired", 1, 0);
      finish_run();
   end

   initial begin
      do_reset();
      // R2 reset state
      @(negedge clk);
      check("R2 tap midscale", tap_sel, 7'h40);
      check("R9 no shutdown after reset", shutdown_o, 0);
      rd(2'd0, 8'h40, "R2 wiper read");
      rd(2'd2, 8'h80, "R7 ctrl reset");
      // R3 recall
      @(negedge clk); nv_ready = 1'b1;
      @(negedge clk);
      check("R3 recall loads initial value", tap_sel, 7'h15);
      // R4 recall only once
      wr(2'd0, 8'h10);
      nv_ready = 1'b0; @(negedge clk); nv_ready = 1'b1; @(negedge clk);
      check("R4 no second recall", tap_sel, 7'h10);
      // R6 reserved addresses
      wr(2'd1, 8'hFF);
      wr(2'd3, 8'hFF);
      rd(2'd1, 8'h00, "R6 addr1 reads zero");
      rd(2'd3, 8'h00, "R6 addr3 reads zero");
      rd(2'd0, 8'h10, "R6 wiper untouched");
      rd(2'd2, 8'h80, "R6 ctrl untouched");
      // R1 wiper range
      wr(2'd0, 8'hFF);
      check("R1 tap full scale", tap_sel, 7'h7F);
      rd(2'd0, 8'h7F, "R1 msb reads zero");
      wr(2'd0, 8'h00);
      check("R1 tap zero", tap_sel, 7'h00);
      // R8 non-volatile writes and busy
      wr(2'd2, 8'hC0);
      wr(2'd0, 8'h33);
      check("R8 nv write moves wiper", tap_sel, 7'h33);
      rd(2'd0, 8'h33, "R8 initial value updated");
      rd(2'd2, 8'hE0, "R8 busy flag set");
      wr(2'd0, 8'h44);
      check("R8 wiper takes write while busy", tap_sel, 7'h44);
      rd(2'd0, 8'h33, "R8 store ignores write while busy");
      repeat (20) @(negedge clk);
      rd(2'd2, 8'hC0, "R8 busy cleared");
      wr(2'd0, 8'h55);
      rd(2'd0, 8'h55, "R8 store written after busy");
      wr(2'd2, 8'h80);
      rd(2'd0, 8'h55, "R7 volatile read shows wiper");
      wr(2'd0, 8'h22);
      wr(2'd2, 8'hC0);
      rd(2'd0, 8'h55, "R8 volatile write leaves store");
      wr(2'd2, 8'h80);
      repeat (20) @(negedge clk);
      // R9 / R10 shutdown
      shdn_n_pin = 1'b0; #1;
      check("R9 pin shutdown flag", shutdown_o, 1);
      check("R9 pin shutdown tap", tap_sel, 7'h00);
      wr(2'd0, 8'h5A);
      check("R10 tap stays low in shutdown", tap_sel, 7'h00);
      rd(2'd0, 8'h5A, "R10 write accepted in shutdown");
      rd(2'd2, 8'h80, "R10 ctrl readable in shutdown");
      @(negedge clk); shdn_n_pin = 1'b1; #1;
      check("R9 release restores tap", tap_sel, 7'h5A);
      check("R9 release clears flag", shutdown_o, 0);
      wr(2'd2, 8'h00);
      check("R9 run bit shutdown flag", shutdown_o, 1);
      check("R9 run bit shutdown tap", tap_sel, 7'h00);
      rd(2'd2, 8'h00, "R10 ctrl read in shutdown");
      wr(2'd2, 8'h80);
      check("R9 run bit release", tap_sel, 7'h5A);
      // R11 read data holds
      rd(2'd2, 8'h80, "R11 read");
      reg_addr = 2'd0;
      repeat (3) @(negedge clk);
      check("R11 read data held", reg_rdata, 8'h80);
      // R5 write held before recall
      do_reset();
      wr(2'd0, 8'h2A);
      check("R5 write held before recall", tap_sel, 7'h40);
      rd(2'd0, 8'h40, "R5 wiper still midscale");
      @(negedge clk); nv_ready = 1'b1;
      @(negedge clk);
      check("R5 held write wins over recall", tap_sel, 7'h2A);
      repeat (3) @(negedge clk);
      check("scoreboard drained", exp_q.size(), 0);
      finish_run();
   end
endmodule